// File: doc/BRIEF.md
# Select-Coded Byte ALU

This block computes one of sixteen operations on two byte-wide operands and hands the result, with a carry flag, to a downstream consumer through a one-entry output register. The upper two bits of a four-bit operation code pick the operation family: add/subtract, bitwise, left shift or right shift. The lower two bits and the carry input pick the variant inside the arithmetic and bitwise families. In the arithmetic family, decrement is one variant of the shared adder and not a separate unit.

A micro-operation such as "R gets R1 + R2" is issued by driving R1 on `op_a_i`, R2 on `op_b_i` and the operation code, with `in_valid_i` high. The result comes out of the register one clock after the transfer is accepted. For a shift of R2, R2 is driven on `op_a_i`. Both sides use a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high. The producer must hold its operands and code stable while `in_valid_i` is high and `in_ready_o` is low. The output holds its value until the consumer takes it. When the consumer stalls with `out_ready_i` low and a result is pending, `in_ready_o` drops and the stall passes back to the producer.

Top module: `bytealu_top`

## Requirements
- R1: Code 0001 gives result = a + b + carry-in (low 8 bits). The carry flag is bit 8 of the 9-bit sum.
- R2: The other arithmetic codes (top bits 00) each add a + k + carry-in and take bit 8 of the 9-bit sum as the carry flag. The addend k is 0 for code 0000, the bitwise inverse of b for code 0010, and 0xFF for code 0011. So code 0011 with carry-in 0 is a decrement of a.
- R3: Codes 01xx are bitwise operations: 00 = a AND b, 01 = a OR b, 10 = a XOR b, 11 = NOT a. The carry flag is 0 and carry-in has no effect.
- R4: Codes 10xx shift a left by one, filling bit 0 with 0. The carry flag is the old bit 7. Code bits 1:0 and carry-in have no effect.
- R5: Codes 11xx shift a right by one, filling bit 7 with 0. The carry flag is the old bit 0.
- R6: While reset (active low) is held and after it is released, `out_valid_o` is 0 until the first transfer is accepted.
- R7: An accepted input transfer makes `out_valid_o` high on the next clock, carrying that transfer's result. If the result is consumed and no new transfer is accepted, `out_valid_o` goes low.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the result, the carry flag and `out_valid_o` stay unchanged.
- R9: `in_ready_o` is high exactly when no result is pending or the consumer is ready.
- R10: For a = 0x1C and b = 0x7E: add gives 0x9A with carry 0, XOR gives 0x62, a left shift of 0x7E gives 0xFC, and decrement of 0x1C gives 0x1B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Reset, active low |
| in_valid_i | input | 1 | Operands and code are valid |
| in_ready_o | output | 1 | Block can accept a transfer |
| op_a_i | input | 8 | First operand (a); the one shifted |
| op_b_i | input | 8 | Second operand (b) |
| code_i | input | 4 | Operation code: bits 3:2 family, bits 1:0 variant |
| carry_i | input | 1 | Carry input |
| out_valid_o | output | 1 | Registered result is pending |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry flag |

## Verification
Directed cases cover the worked example values. They also cover the wrap points: 0xFF + 0x01 with carry-in, decrement of 0x00, and an increment of 0xFF. These show whether the carry is taken from bit 8 of the sum and whether carry-in really enters the adder. Walking-one operands on both shifts show whether the fill bit, the direction and the bit that leaves are correct. Seeded random operands, codes and carry-in values exercise every family. In the bitwise and shift families, they show that carry-in and the unused code bits change nothing. A directed stall sequence holds the consumer off while a second transfer is offered. It shows whether the output register holds, whether `in_ready_o` blocks the new transfer, and whether that transfer is taken once the stall ends.

// File: rtl/bytealu_pkg.sv
package bytealu_pkg;
  typedef enum logic [1:0] {
    FAM_ARITH = 2'b00,
    FAM_BITW  = 2'b01,
    FAM_SHL   = 2'b10,
    FAM_SHR   = 2'b11
  } fam_e;

  typedef enum logic [1:0] {
    BW_AND = 2'b00,
    BW_OR  = 2'b01,
    BW_XOR = 2'b10,
    BW_NOT = 2'b11
  } bitw_e;
endpackage

// File: rtl/bytealu_arith.sv
module bytealu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   var_i,
  input  logic         cin_i,
  output logic [W-1:0] f_o,
  output logic         c_o
);
  logic [W-1:0] addend;
  logic [W:0]   sum;

  always_comb begin
    unique case (var_i)
      2'b00:   addend = '0;
      2'b01:   addend = b_i;
      2'b10:   addend = ~b_i;
      default: addend = '1;
    endcase
    sum = {1'b0, a_i} + {1'b0, addend} + {{W{1'b0}}, cin_i};
  end

  assign f_o = sum[W-1:0];
  assign c_o = sum[W];
endmodule

// File: rtl/bytealu_bitw.sv
module bytealu_bitw
  import bytealu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   var_i,
  output logic [W-1:0] f_o
);
  always_comb begin
    unique case (bitw_e'(var_i))
      BW_AND:  f_o = a_i & b_i;
      BW_OR:   f_o = a_i | b_i;
      BW_XOR:  f_o = a_i ^ b_i;
      default: f_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/bytealu_shift.sv
module bytealu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         right_i,
  output logic [W-1:0] f_o,
  output logic         c_o
);
  always_comb begin
    if (right_i) begin
      f_o = {1'b0, a_i[W-1:1]};
      c_o = a_i[0];
    end else begin
      f_o = {a_i[W-2:0], 1'b0};
      c_o = a_i[W-1];
    end
  end
endmodule

// File: rtl/bytealu_top.sv
module bytealu_top
  import bytealu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [3:0]   code_i,
  input  logic         carry_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  localparam int MSB = W - 1;

  fam_e       fam;
  logic [1:0] var_sel;
  assign fam     = fam_e'(code_i[3:2]);
  assign var_sel = code_i[1:0];

  logic [W-1:0] ar_f, bw_f, sh_f;
  logic         ar_c, sh_c;

  bytealu_arith #(.W(W)) u_arith (
    .a_i(op_a_i), .b_i(op_b_i), .var_i(var_sel), .cin_i(carry_i),
    .f_o(ar_f), .c_o(ar_c)
  );

  bytealu_bitw #(.W(W)) u_bitw (
    .a_i(op_a_i), .b_i(op_b_i), .var_i(var_sel), .f_o(bw_f)
  );

  bytealu_shift #(.W(W)) u_shift (
    .a_i(op_a_i), .right_i(code_i[2]), .f_o(sh_f), .c_o(sh_c)
  );

  logic [W-1:0] nxt_f;
  logic         nxt_c;

  always_comb begin
    unique case (fam)
      FAM_ARITH: begin nxt_f = ar_f; nxt_c = ar_c; end
      FAM_BITW:  begin nxt_f = bw_f; nxt_c = 1'b0; end
      default:   begin nxt_f = sh_f; nxt_c = sh_c; end
    endcase
  end

  logic take;
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_o       <= '0;
      carry_o     <= 1'b0;
    end else if (take) begin
      out_valid_o <= 1'b1;
      res_o       <= nxt_f;
      carry_o     <= nxt_c;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // R7
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> out_valid_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(res_o) && $stable(carry_o)));

  // R1
  add_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && code_i == 4'b0001) |=>
      ({carry_o, res_o} == $past({1'b0, op_a_i} + {1'b0, op_b_i} + {{W{1'b0}}, carry_i})));

  // R3
  bitw_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && code_i[3:2] == 2'b01) |=> !carry_o);

  // R4
  shl_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && code_i[3:2] == 2'b10) |=> (carry_o == $past(op_a_i[MSB]) && !res_o[0]));

  // R5
  shr_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && code_i[3:2] == 2'b11) |=> (carry_o == $past(op_a_i[0]) && !res_o[MSB]));
endmodule

// File: tb/bytealu_top_test.sv
module bytealu_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] opa = '0, opb = '0;
  logic [3:0] code = '0;
  logic       cin = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] res;
  logic       cout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bytealu_top uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_a_i(opa), .op_b_i(opb), .code_i(code), .carry_i(cin),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .res_o(res), .carry_o(cout)
  );

  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [3:0] s, input logic c);
    logic [8:0] t;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: t = {1'b0, a} + {8'd0, c};
          2'b01: t = {1'b0, a} + {1'b0, b} + {8'd0, c};
          2'b10: t = {1'b0, a} + {1'b0, ~b} + {8'd0, c};
          default: t = {1'b0, a} + 9'h0FF + {8'd0, c};
        endcase
      end
      2'b01: begin
        case (s[1:0])
          2'b00: t = {1'b0, a & b};
          2'b01: t = {1'b0, a | b};
          2'b10: t = {1'b0, a ^ b};
          default: t = {1'b0, ~a};
        endcase
      end
      2'b10: t = {a[7], a[6:0], 1'b0};
      default: t = {a[0], 1'b0, a[7:1]};
    endcase
    return t;
  endfunction

  function automatic string req_of(input logic [3:0] s);
    if (s == 4'b0001) return "R1";
    case (s[3:2])
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one op with consumer ready; check one cycle later
  task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                        input logic [3:0] s, input logic c, input string req);
    logic [8:0] e;
    e = model(a, b, s, c);
    @(negedge clk);
    opa = a; opb = b; code = s; cin = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, "/R7 valid"}, {31'd0, out_valid}, 32'd1);
    check(req, {23'd0, cout, res}, {23'd0, e});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [8:0] ea, eb;
    void'($urandom(32'd20141));
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6", {31'd0, out_valid}, 32'd0);
    check("R9 idle", {31'd0, in_ready}, 32'd1);

    // R10 worked example
    run_op(8'h1C, 8'h7E, 4'b0001, 1'b0, "R10 add");
    check("R10 add", {24'd0, res}, 32'h9A);
    run_op(8'h1C, 8'h7E, 4'b0110, 1'b1, "R10 xor");
    check("R10 xor", {24'd0, res}, 32'h62);
    run_op(8'h7E, 8'h1C, 4'b1011, 1'b1, "R10 shl");
    check("R10 shl", {24'd0, res}, 32'hFC);
    run_op(8'h1C, 8'h7E, 4'b0011, 1'b0, "R10 dec");
    check("R10 dec", {24'd0, res}, 32'h1B);

    // corners
    run_op(8'hFF, 8'h01, 4'b0001, 1'b1, "R1 wrap");
    run_op(8'h00, 8'h55, 4'b0011, 1'b0, "R2 dec zero");
    run_op(8'hFF, 8'h00, 4'b0000, 1'b1, "R2 inc wrap");
    run_op(8'h40, 8'h40, 4'b0010, 1'b1, "R2 sub");
    run_op(8'hA5, 8'h0F, 4'b0111, 1'b1, "R3 not");
    run_op(8'hA5, 8'h0F, 4'b0111, 1'b0, "R3 not");
    run_op(8'hFF, 8'hFF, 4'b0100, 1'b1, "R3 and");
    for (int i = 0; i < 8; i++) begin
      run_op(8'h01 << i, 8'h00, 4'b1000 | 4'(i[1:0]), i[2], "R4 walk");
      run_op(8'h01 << i, 8'h00, 4'b1100 | 4'(i[1:0]), i[2], "R5 walk");
    end

    // R7: result consumed, no new transfer -> valid drops
    @(negedge clk);
    check("R7 drop", {31'd0, out_valid}, 32'd0);

    // R8/R9 stall
    ea = model(8'h33, 8'h44, 4'b0001, 1'b0);
    eb = model(8'h81, 8'h00, 4'b1100, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    opa = 8'h33; opb = 8'h44; code = 4'b0001; cin = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R7 stall", {31'd0, out_valid}, 32'd1);
    check("R1 stall", {23'd0, cout, res}, {23'd0, ea});
    check("R9 stall", {31'd0, in_ready}, 32'd0);
    opa = 8'h81; opb = 8'h00; code = 4'b1100;
    repeat (3) begin
      @(negedge clk);
      check("R8 hold", {22'd0, out_valid, cout, res}, {22'd0, 1'b1, ea});
    end
    out_ready = 1'b1;
    #0.5;
    check("R9 release", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next", {23'd0, cout, res}, {23'd0, eb});
    @(negedge clk);
    check("R7 drop", {31'd0, out_valid}, 32'd0);

    // random
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a, b;
      logic [3:0] s;
      logic c;
      a = 8'($urandom); b = 8'($urandom); s = 4'($urandom); c = 1'($urandom);
      run_op(a, b, s, c, req_of(s));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule